// File: doc/BRIEF.md
# DRAM Refresh Address Generator

This block produces the refresh cycles that a video controller places into every raster line to keep dynamic RAM alive. The controller marks each memory slot it owns with a strobe and marks the start of each raster line with a pulse. A fixed group of those slots, counted from the line start, is handed to refresh. In each of them the block drives an address on a fixed high page, with the low byte taken from a persistent down counter, and it derives the DRAM row address from that address.

The row strobe request is raised on every owned slot. This covers refresh slots and the fetch slots that other logic fills. The column strobe request can be suppressed by an external decode input. The row address, and so the refresh itself, reaches the RAM whatever that decode selects. A strap input narrows the row address to seven bits for smaller DRAMs.

Top module: `rfsh_gen`

## Requirements
- R1: After reset no refresh cycle occurs until the first line-start pulse. The refresh counter starts at 0xFF, so the first refresh address is 0x3FFF.
- R2: Slots are numbered from 0, counting the strobed cycles that follow the line-start cycle. Refresh runs on exactly slots 3, 4, 5, 6 and 7 of a line. `rfsh_act` is high only in those slot cycles, so a line never holds more than five refreshes.
- R3: During a refresh, `addr[13:8]` is 6'b111111 and `addr[7:0]` is the counter value. Outside refresh, `addr` is zero.
- R4: The counter decreases by one after each refresh and wraps from 0x00 to 0xFF. It holds its value between lines, so each line continues from the value the previous line left.
- R5: When `row7_sel` is 0, `row_addr` equals `addr[7:0]`.
- R6: When `row7_sel` is 1, `row_addr[7]` is 0 and `row_addr[6:0]` equals `addr[6:0]`.
- R7: `ras_req` is high in every cycle with `slot_stb` high, on refresh and fetch slots alike, whatever the value of `cas_inhibit`.
- R8: `cas_req` is high in a slot cycle exactly when `cas_inhibit` is 0. This holds on refresh slots as well.
- R9: A line-start pulse restarts slot numbering. Refreshes that a short line did not reach are dropped, not carried into the next line.
- R10: In a cycle with `slot_stb` low, `ras_req`, `cas_req` and `rfsh_act` are low and the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of a raster line |
| slot_stb | input | 1 | High in each cycle that is a controller-owned memory slot |
| row7_sel | input | 1 | Strap: 1 selects a 7-bit row address |
| cas_inhibit | input | 1 | External decode: 1 suppresses the column strobe request |
| addr | output | 14 | Memory address; refresh page plus counter during refresh |
| rfsh_act | output | 1 | High during a refresh slot |
| row_addr | output | 8 | DRAM row address |
| ras_req | output | 1 | Row strobe request |
| cas_req | output | 1 | Column strobe request |

## Verification
Slots are driven before any line start, to separate a missing power-up guard from the refresh window. Full ten-slot lines with the column inhibit toggling show that the window falls on exactly slots 3 to 7 and that only the column strobe follows the decode. Lines are repeated with the 7-bit strap set, and a four-slot line is placed before a full one, to show that the row bit is masked and that a cut line drops the refreshes it did not reach. Idle gaps inside lines and a run of more than 256 refreshes show that the counter holds still when no slot is strobed and that it wraps through zero.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int unsigned RF_ADDR_W  = 14;
  localparam int unsigned RF_CTR_W   = 8;
  localparam int unsigned RF_SLOT_W  = 6;
  localparam int unsigned RF_OFS     = 3;
  localparam int unsigned RF_NUM     = 5;
endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rfsh_slot_seq.sv
module rfsh_slot_seq #(
  parameter int unsigned SLOT_W = rfsh_pkg::RF_SLOT_W,
  parameter int unsigned OFS    = rfsh_pkg::RF_OFS,
  parameter int unsigned NUM    = rfsh_pkg::RF_NUM
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic slot_stb,
  output logic rfsh_act
);
  localparam logic [SLOT_W-1:0] WIN_LO  = SLOT_W'(OFS);
  localparam logic [SLOT_W-1:0] WIN_HI  = SLOT_W'(OFS + NUM);
  localparam logic [SLOT_W-1:0] SAT_MAX = '1;
  localparam int unsigned CHK_W = $clog2(NUM + 2);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_en;
  logic              in_win;

  // Slot index saturates so that long lines never reopen the window
  always_comb begin
    slot_en = line_start || (slot_stb && (slot_q != SAT_MAX));
    slot_d  = slot_q;
    if (line_start)   slot_d = '0;
    else if (slot_en) slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= SAT_MAX;
    else if (slot_en) slot_q <= slot_d;
  end

  assign in_win   = (slot_q >= WIN_LO) && (slot_q < WIN_HI);
  assign rfsh_act = slot_stb && !line_start && in_win;

  // Checker support: refreshes counted inside the current line
  logic [CHK_W-1:0] chk_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chk_cnt_q <= '0;
    else if (line_start) chk_cnt_q <= '0;
    else if (rfsh_act)   chk_cnt_q <= chk_cnt_q + 1'b1;
  end

  AST_FIVE_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_act |-> (chk_cnt_q < CHK_W'(NUM))) else $error("AST_FIVE_PER_LINE"); // R2
  AST_REFRESH_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |-> !rfsh_act) else $error("AST_REFRESH_IN_SLOT"); // R10
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (slot_q == '0)) else $error("AST_LINE_RESTART"); // R9
endmodule

// File: rtl/rfsh_ctr.sv
module rfsh_ctr #(
  parameter int unsigned CTR_W = rfsh_pkg::RF_CTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CTR_W-1:0] ctr_q
);
  logic [CTR_W-1:0] ctr_d;

  always_comb begin
    ctr_d = ctr_q;
    if (step) ctr_d = ctr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctr_q <= '1;
    else if (step) ctr_q <= ctr_d;
  end

  AST_CTR_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ctr_q == CTR_W'($past(ctr_q) - 1'b1))) else $error("AST_CTR_DECR"); // R4
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ctr_q)) else $error("AST_CTR_HOLD"); // R10
endmodule

// File: rtl/rfsh_row_mux.sv
module rfsh_row_mux #(
  parameter int unsigned ROW_W = rfsh_pkg::RF_CTR_W
) (
  input  logic [ROW_W-1:0] addr_lo,
  input  logic             row7_sel,
  output logic [ROW_W-1:0] row_addr
);
  for (genvar i = 0; i < ROW_W; i++) begin : g_row
    if (i == ROW_W - 1) begin : g_top
      assign row_addr[i] = addr_lo[i] & ~row7_sel;
    end else begin : g_low
      assign row_addr[i] = addr_lo[i];
    end
  end
endmodule

// File: rtl/rfsh_gen.sv
module rfsh_gen #(
  parameter int unsigned ADDR_W = rfsh_pkg::RF_ADDR_W,
  parameter int unsigned CTR_W  = rfsh_pkg::RF_CTR_W,
  parameter int unsigned SLOT_W = rfsh_pkg::RF_SLOT_W,
  parameter int unsigned OFS    = rfsh_pkg::RF_OFS,
  parameter int unsigned NUM    = rfsh_pkg::RF_NUM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              slot_stb,
  input  logic              row7_sel,
  input  logic              cas_inhibit,
  output logic [ADDR_W-1:0] addr,
  output logic              rfsh_act,
  output logic [CTR_W-1:0]  row_addr,
  output logic              ras_req,
  output logic              cas_req
);
  localparam int unsigned PAGE_W = ADDR_W - CTR_W;
  localparam logic [PAGE_W-1:0] PAGE = '1;

  logic             rst_sync_n;
  logic [CTR_W-1:0] ctr;

  rfsh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rfsh_slot_seq #(.SLOT_W(SLOT_W), .OFS(OFS), .NUM(NUM)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_start (line_start),
    .slot_stb   (slot_stb),
    .rfsh_act   (rfsh_act)
  );

  rfsh_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (rfsh_act),
    .ctr_q (ctr)
  );

  assign addr = rfsh_act ? {PAGE, ctr} : '0;

  rfsh_row_mux #(.ROW_W(CTR_W)) u_row (
    .addr_lo  (addr[CTR_W-1:0]),
    .row7_sel (row7_sel),
    .row_addr (row_addr)
  );

  // Row strobe on every owned slot; only the column strobe obeys decode
  assign ras_req = slot_stb;
  assign cas_req = slot_stb & ~cas_inhibit;

  AST_RFSH_PAGE_RAS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rfsh_act |-> (ras_req && (addr[ADDR_W-1:CTR_W] == PAGE))) else $error("AST_RFSH_PAGE_RAS"); // R7
  AST_RFSH_CAS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rfsh_act && !cas_inhibit) |-> cas_req) else $error("AST_RFSH_CAS"); // R8
  AST_ROW_NARROW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    row7_sel |-> !row_addr[CTR_W-1]) else $error("AST_ROW_NARROW"); // R6
endmodule

// File: tb/tb_rfsh_gen.sv
module tb_rfsh_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        slot_stb = 1'b0;
  logic        row7_sel = 1'b0;
  logic        cas_inhibit = 1'b0;
  logic [13:0] addr;
  logic        rfsh_act;
  logic [7:0]  row_addr;
  logic        ras_req;
  logic        cas_req;

  always #10 clk = ~clk;

  rfsh_gen dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .slot_stb(slot_stb),
    .row7_sel(row7_sel), .cas_inhibit(cas_inhibit), .addr(addr),
    .rfsh_act(rfsh_act), .row_addr(row_addr), .ras_req(ras_req), .cas_req(cas_req)
  );

  typedef struct {
    logic [13:0] addr;
    logic        act;
    logic [7:0]  row;
    logic        cas;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   m_idx = 63;
  logic [7:0] m_ctr = 8'hFF;
  int   n_rfsh = 0;
  bit   wrapped = 0;
  bit   done = 0;

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  // Driver: model from requirements R1..R4, R5/R6, R8
  task automatic slot(input logic inh);
    exp_t e;
    @(negedge clk);
    line_start  = 1'b0;
    slot_stb    = 1'b1;
    cas_inhibit = inh;
    e.act = (m_idx >= 3) && (m_idx < 8);
    e.addr = e.act ? {6'h3F, m_ctr} : 14'h0;
    e.row = row7_sel ? {1'b0, e.addr[6:0]} : e.addr[7:0];
    e.cas = ~inh;
    q.push_back(e);
    if (e.act) begin
      if (m_ctr == 8'h00) wrapped = 1;
      m_ctr = m_ctr - 8'h01;
      n_rfsh++;
    end
    if (m_idx < 63) m_idx++;
  endtask

  task automatic idle();
    @(negedge clk);
    line_start = 1'b0;
    slot_stb   = 1'b0;
  endtask

  task automatic new_line();
    @(negedge clk);
    line_start = 1'b1;
    slot_stb   = 1'b0;
    m_idx      = 0;
  endtask

  task automatic full_line(input int nslots, input bit gaps);
    new_line();
    for (int i = 0; i < nslots; i++) begin
      slot(logic'(i % 2));
      if (gaps && (i % 3 == 1)) idle();
    end
  endtask

  // Monitor: samples mid-low-phase, after inputs settle
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      if (slot_stb) begin
        exp_t e;
        if (q.size() == 0) begin
          chk("R2 queue empty", 1, 0);
        end else begin
          e = q.pop_front();
          chk("R2 rfsh_act", int'(rfsh_act), int'(e.act));
          chk("R3 addr", int'(addr), int'(e.addr));
          chk("R5/R6 row_addr", int'(row_addr), int'(e.row));
          chk("R7 ras_req", int'(ras_req), 1);
          chk("R8 cas_req", int'(cas_req), int'(e.cas));
        end
      end else begin
        chk("R10 idle strobes", int'({ras_req, cas_req, rfsh_act}), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset addr", int'(addr), 0);
    chk("R1 reset strobes", int'({rfsh_act, ras_req, cas_req}), 0);
    rst_n = 1'b1;
    repeat (4) idle();
    // R1: slots before any line start give no refresh
    for (int i = 0; i < 10; i++) slot(1'b0);
    idle();
    // R2, R3, R5, R7, R8: full lines, first refresh address 0x3FFF per R1
    full_line(10, 0);
    full_line(10, 1);
    // R6: narrow row strap
    row7_sel = 1'b1;
    full_line(10, 0);
    full_line(12, 1);
    row7_sel = 1'b0;
    // R9: a short line cuts the window; next line starts fresh
    full_line(4, 0);
    full_line(10, 0);
    full_line(2, 0);
    full_line(6, 1);
    full_line(10, 0);
    // R4: run past a counter wrap, alternating strap
    for (int l = 0; l < 56; l++) begin
      row7_sel = logic'(l % 2);
      full_line(9, (l % 4) == 0);
    end
    idle();
    idle();
    chk("R4 wrap reached", int'(wrapped), 1);
    chk("R2 queue drained", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule